// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block holds the hazard-control logic of a five-stage in-order pipeline: fetch, decode, execute, memory access and write-back. Each cycle it looks at the register numbers, write enables and load flags of the instructions in decode, execute, memory and write-back. It also looks at a flag showing that the memory stage is using a single memory port shared with fetch, and at the branch resolution signals. From these it produces the operand bypass selects for execute, the hold and nop controls for the front of the pipeline, and the flush controls for the younger stages.

Three kinds of hazard are handled in one place. A dependent instruction takes a result that has not yet been written back from the bypass network. A load followed directly by a consumer costs exactly one bubble. A memory-stage access on the shared port holds fetch for that cycle. A branch misprediction clears the wrong-path instructions. The unit is purely combinational; the pipeline registers, datapath and predictor sit outside it. The parameter `BR_IN_MEM` chooses where branches resolve: in execute, with a two-cycle penalty, or in memory, with a three-cycle penalty.

Top module: `hazard_unit`

## Requirements
- R1: When the memory-stage instruction writes a nonzero register, is not a load, and its destination equals an execute source, that operand's select is 2'b10 (take the memory-stage result).
- R2: When R1 does not apply and the write-back instruction writes a nonzero register equal to an execute source, that operand's select is 2'b01 (take the write-back result).
- R3: When the memory-stage and write-back destinations both match the same execute source, the memory-stage (younger) result wins with select 2'b10.
- R4: Register 0 is never forwarded, and a load writing register 0 never causes a stall.
- R5: With no matching producer, a producer whose write enable is low, or a matching load still in the memory stage, the select is 2'b00 (register-file value).
- R6: A load in execute whose nonzero destination equals either decode source raises stall_fetch, hold_decode and bubble_exec for that cycle. A non-load producer causes no stall, and the load-use pair inserts exactly one bubble as the load moves on.
- R7: While mem_port_busy is high, stall_fetch is high. kill_decode is also high (a nop enters decode), unless a load-use stall holds decode, in which case kill_decode is low and hold_decode is high. This holds even during a flush.
- R8: When br_resolved and br_mispredict are both high, kill_decode and flush_exec are high, and flush_mem is high only when BR_IN_MEM is 1.
- R9: A misprediction overrides a load-use stall in the same cycle: hold_decode and bubble_exec are low and the wrong-path instructions are flushed.
- R10: br_mispredict without br_resolved, or br_resolved without br_mispredict, causes no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src_a | input | REG_W | First source register of the decode instruction |
| id_src_b | input | REG_W | Second source register of the decode instruction |
| ex_src_a | input | REG_W | First source register of the execute instruction |
| ex_src_b | input | REG_W | Second source register of the execute instruction |
| ex_dst | input | REG_W | Destination of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | REG_W | Destination of the write-back instruction |
| wb_wr_en | input | 1 | Write-back instruction writes a register |
| mem_port_busy | input | 1 | Memory stage uses the shared memory port this cycle |
| br_resolved | input | 1 | A branch resolves this cycle |
| br_mispredict | input | 1 | The resolving branch was mispredicted |
| fwd_a | output | 2 | Operand A select: 00 register file, 01 write-back, 10 memory stage |
| fwd_b | output | 2 | Operand B select, same encoding |
| stall_fetch | output | 1 | Fetch performs no access and the PC holds |
| hold_decode | output | 1 | Decode register keeps its instruction |
| kill_decode | output | 1 | Decode register loads a nop |
| bubble_exec | output | 1 | Execute register loads a nop for a stall |
| flush_exec | output | 1 | Execute register loads a nop for a misprediction |
| flush_mem | output | 1 | Memory-stage register loads a nop for a misprediction |

## Verification
The bench builds the block with REG_W = 5, so register 0 and a full range of nonzero registers can be reached. It builds two copies, one with BR_IN_MEM = 1 and one with the default of 0, so the three-cycle flush depth and the two-cycle flush depth are both observed on the same stimulus. Beyond the single-cycle vectors, short stage-by-stage traces replay an add followed by a dependent subtract, and a load followed by its consumer as it drains toward write-back.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int REG_W     = 5,
  parameter bit BR_IN_MEM = 1'b0
) (
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wr_en,
  input  logic             ex_is_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wr_en,
  input  logic             mem_is_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wr_en,
  input  logic             mem_port_busy,
  input  logic             br_resolved,
  input  logic             br_mispredict,
  output logic [1:0]       fwd_a,
  output logic [1:0]       fwd_b,
  output logic             stall_fetch,
  output logic             hold_decode,
  output logic             kill_decode,
  output logic             bubble_exec,
  output logic             flush_exec,
  output logic             flush_mem
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic [1:0][REG_W-1:0] ex_src;
  logic [1:0][1:0]       sel;
  logic                  mem_can_fwd, wb_can_fwd;
  logic                  load_use, data_stall, redirect;

  assign ex_src      = {ex_src_b, ex_src_a};
  assign mem_can_fwd = mem_wr_en && !mem_is_load && (mem_dst != ZERO_REG);
  assign wb_can_fwd  = wb_wr_en && (wb_dst != ZERO_REG);

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    assign sel[i] = (mem_can_fwd && mem_dst == ex_src[i]) ? 2'b10 :
                    (wb_can_fwd  && wb_dst  == ex_src[i]) ? 2'b01 : 2'b00;
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  assign redirect   = br_resolved && br_mispredict;
  assign load_use   = ex_wr_en && ex_is_load && (ex_dst != ZERO_REG) &&
                      (ex_dst == id_src_a || ex_dst == id_src_b);
  assign data_stall = load_use && !redirect;

  assign stall_fetch = data_stall || mem_port_busy;
  assign hold_decode = data_stall;
  assign kill_decode = redirect || (mem_port_busy && !data_stall);
  assign bubble_exec = data_stall;
  assign flush_exec  = redirect;

  if (BR_IN_MEM) begin : g_late_resolve
    assign flush_mem = redirect;
  end else begin : g_early_resolve
    assign flush_mem = 1'b0;
  end
endmodule

module hazard_unit_chk #(
  parameter int REG_W     = 5,
  parameter bit BR_IN_MEM = 1'b0
) (
  input logic [REG_W-1:0] id_src_a,
  input logic [REG_W-1:0] id_src_b,
  input logic [REG_W-1:0] ex_src_a,
  input logic [REG_W-1:0] ex_dst,
  input logic             ex_wr_en,
  input logic             ex_is_load,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_wr_en,
  input logic             mem_is_load,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_wr_en,
  input logic             mem_port_busy,
  input logic             br_resolved,
  input logic             br_mispredict,
  input logic [1:0]       fwd_a,
  input logic             stall_fetch,
  input logic             hold_decode,
  input logic             kill_decode,
  input logic             bubble_exec,
  input logic             flush_exec,
  input logic             flush_mem
);
  always_comb begin
    assert_mem_fwd_R1: assert (!(mem_wr_en && !mem_is_load && mem_dst != '0 &&
                                 mem_dst == ex_src_a) || fwd_a == 2'b10);
    assert_wb_fwd_R2: assert (!(wb_wr_en && wb_dst != '0 && wb_dst == ex_src_a &&
                                !(mem_wr_en && !mem_is_load && mem_dst == ex_src_a)) ||
                              fwd_a == 2'b01);
    assert_zero_reg_R4: assert (ex_src_a != '0 || fwd_a == 2'b00);
    assert_no_writer_R5: assert (mem_wr_en || wb_wr_en || fwd_a == 2'b00);
    assert_load_use_R6: assert (!(ex_wr_en && ex_is_load && ex_dst != '0 &&
                                  (ex_dst == id_src_a || ex_dst == id_src_b) &&
                                  !(br_resolved && br_mispredict)) ||
                                (stall_fetch && hold_decode && bubble_exec));
    assert_port_R7: assert (!mem_port_busy || (stall_fetch && (kill_decode != hold_decode)));
    assert_flush_R8: assert (!(br_resolved && br_mispredict) ||
                             (kill_decode && flush_exec && flush_mem == BR_IN_MEM));
    assert_flush_wins_R9: assert (!(br_resolved && br_mispredict) ||
                                  (!hold_decode && !bubble_exec));
    assert_no_flush_R10: assert ((br_resolved && br_mispredict) || (!flush_exec && !flush_mem));
  end
endmodule

bind hazard_unit hazard_unit_chk #(.REG_W(REG_W), .BR_IN_MEM(BR_IN_MEM)) u_chk (
  .id_src_a(id_src_a), .id_src_b(id_src_b), .ex_src_a(ex_src_a), .ex_dst(ex_dst),
  .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load), .mem_dst(mem_dst),
  .mem_wr_en(mem_wr_en), .mem_is_load(mem_is_load), .wb_dst(wb_dst),
  .wb_wr_en(wb_wr_en), .mem_port_busy(mem_port_busy), .br_resolved(br_resolved),
  .br_mispredict(br_mispredict), .fwd_a(fwd_a), .stall_fetch(stall_fetch),
  .hold_decode(hold_decode), .kill_decode(kill_decode), .bubble_exec(bubble_exec),
  .flush_exec(flush_exec), .flush_mem(flush_mem)
);

// File: tb/sim_hazard_unit.sv
module sim_hazard_unit;
  localparam int RW = 5;
  localparam int NV = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [RW-1:0] id_a, id_b, ex_a, ex_b, ex_d, mem_d, wb_d;
  logic ex_w, ex_l, mem_w, mem_l, wb_w, busy, res, mis;
  logic [1:0] fa, fb, fa1, fb1;
  logic spc, hold, kill, bub, fex, fmem;
  logic spc1, hold1, kill1, bub1, fex1, fmem1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hazard_unit #(.REG_W(RW), .BR_IN_MEM(1'b1)) u0 (
    .id_src_a(id_a), .id_src_b(id_b), .ex_src_a(ex_a), .ex_src_b(ex_b),
    .ex_dst(ex_d), .ex_wr_en(ex_w), .ex_is_load(ex_l), .mem_dst(mem_d),
    .mem_wr_en(mem_w), .mem_is_load(mem_l), .wb_dst(wb_d), .wb_wr_en(wb_w),
    .mem_port_busy(busy), .br_resolved(res), .br_mispredict(mis),
    .fwd_a(fa), .fwd_b(fb), .stall_fetch(spc), .hold_decode(hold),
    .kill_decode(kill), .bubble_exec(bub), .flush_exec(fex), .flush_mem(fmem));

  hazard_unit #(.REG_W(RW), .BR_IN_MEM(1'b0)) u1 (
    .id_src_a(id_a), .id_src_b(id_b), .ex_src_a(ex_a), .ex_src_b(ex_b),
    .ex_dst(ex_d), .ex_wr_en(ex_w), .ex_is_load(ex_l), .mem_dst(mem_d),
    .mem_wr_en(mem_w), .mem_is_load(mem_l), .wb_dst(wb_d), .wb_wr_en(wb_w),
    .mem_port_busy(busy), .br_resolved(res), .br_mispredict(mis),
    .fwd_a(fa1), .fwd_b(fb1), .stall_fetch(spc1), .hold_decode(hold1),
    .kill_decode(kill1), .bubble_exec(bub1), .flush_exec(fex1), .flush_mem(fmem1));

  // {id_a,id_b,ex_a,ex_b,ex_d,mem_d,wb_d, ex_w,ex_l,mem_w,mem_l,wb_w,busy,res,mis,
  //  fa,fb, stall,hold,kill,bubble,flush_exec,flush_mem}
  localparam logic [52:0] VEC [NV] = '{
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b00000000, 2'b00,2'b00, 6'b000000}, // R5 idle
    {5'd6,5'd7,5'd1,5'd5,5'd4,5'd1,5'd0, 8'b10100000, 2'b10,2'b00, 6'b000000}, // R1 add->sub
    {5'd0,5'd0,5'd2,5'd5,5'd0,5'd9,5'd5, 8'b00101000, 2'b00,2'b01, 6'b000000}, // R2
    {5'd0,5'd0,5'd7,5'd7,5'd0,5'd7,5'd7, 8'b00101000, 2'b10,2'b10, 6'b000000}, // R3
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b11101000, 2'b00,2'b00, 6'b000000}, // R4
    {5'd0,5'd0,5'd3,5'd0,5'd0,5'd3,5'd3, 8'b00000000, 2'b00,2'b00, 6'b000000}, // R5 no write
    {5'd0,5'd0,5'd0,5'd8,5'd0,5'd8,5'd0, 8'b00110000, 2'b00,2'b00, 6'b000000}, // R5 load in mem
    {5'd0,5'd6,5'd0,5'd0,5'd6,5'd0,5'd0, 8'b11000000, 2'b00,2'b00, 6'b110100}, // R6 load-use
    {5'd6,5'd0,5'd0,5'd0,5'd6,5'd0,5'd0, 8'b10000000, 2'b00,2'b00, 6'b000000}, // R6 non-load
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b00000100, 2'b00,2'b00, 6'b101000}, // R7 port
    {5'd0,5'd6,5'd0,5'd0,5'd6,5'd0,5'd0, 8'b11000100, 2'b00,2'b00, 6'b110100}, // R7 port+load-use
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b00000011, 2'b00,2'b00, 6'b001011}, // R8
    {5'd0,5'd6,5'd0,5'd0,5'd6,5'd0,5'd0, 8'b11000011, 2'b00,2'b00, 6'b001011}, // R9
    {5'd0,5'd6,5'd0,5'd0,5'd6,5'd0,5'd0, 8'b11000010, 2'b00,2'b00, 6'b110100}, // R10 resolved ok
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b00000001, 2'b00,2'b00, 6'b000000}, // R10 no resolve
    {5'd0,5'd0,5'd0,5'd0,5'd0,5'd0,5'd0, 8'b00000111, 2'b00,2'b00, 6'b101011}  // R7 port+flush
  };
  localparam int REQ [NV] = '{5, 1, 2, 3, 4, 5, 5, 6, 6, 7, 7, 8, 9, 10, 10, 7};

  task automatic drive(input logic [42:0] v);
    {id_a, id_b, ex_a, ex_b, ex_d, mem_d, wb_d,
     ex_w, ex_l, mem_w, mem_l, wb_w, busy, res, mis} = v;
  endtask

  task automatic chk(input string tag, input logic [9:0] got, input logic [9:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [9:0] outs0();
    return {fa, fb, spc, hold, kill, bub, fex, fmem};
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int bubbles;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R5 reset idle", outs0(), 10'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      drive(VEC[i][52:10]);
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", REQ[i], i), outs0(), VEC[i][9:0]);
    end

    // R8: early-resolve build flushes decode and execute only
    @(posedge clk);
    drive({35'd0, 8'b00000011});
    @(negedge clk);
    chk("R8 execute-resolve depth", {fa1, fb1, spc1, hold1, kill1, bub1, fex1, fmem1},
        10'b00_00_001010);

    // R1: ADD R1,R2,R3 in memory stage, SUB R4,R1,R5 in execute
    @(posedge clk);
    drive({5'd0, 5'd0, 5'd1, 5'd5, 5'd4, 5'd1, 5'd0, 8'b10100000});
    @(negedge clk);
    chk("R1 add-sub forward, no stall", outs0(), 10'b10_00_000000);

    // R6: LW R6 then ADD R8,R6,R2 traced over three cycles
    bubbles = 0;
    @(posedge clk);
    drive({5'd6, 5'd2, 5'd0, 5'd0, 5'd6, 5'd0, 5'd0, 8'b11000000});
    @(negedge clk);
    bubbles += int'(bub);
    chk("R6 load in execute stalls", outs0(), 10'b00_00_110100);
    @(posedge clk);
    drive({5'd6, 5'd2, 5'd0, 5'd0, 5'd0, 5'd6, 5'd0, 8'b00110000});
    @(negedge clk);
    bubbles += int'(bub);
    chk("R6 consumer released", outs0(), 10'b00_00_000000);
    @(posedge clk);
    drive({5'd0, 5'd0, 5'd6, 5'd2, 5'd8, 5'd0, 5'd6, 8'b10001000});
    @(negedge clk);
    bubbles += int'(bub);
    chk("R6 consumer takes write-back value", outs0(), 10'b01_00_000000);
    chk("R6 bubble count", 10'(bubbles), 10'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule